// File: doc/BRIEF.md
# GPIO Bank Control Register File

This block is the register file for one bank of up to 32 general-purpose pins. A host reaches it over a simple word-wide memory-mapped bus with separate read and write strobes. It holds seven per-pin state words: output data, interrupt mask, pull-up disable, function, select, direction and trigger. Toward the pad multiplexer it drives, for each pin, an output value, an output enable, a pull-up enable and a 2-bit alternate-function index. It also returns the synchronized levels of the pins on a read-only word.

Each state word can be written in three ways: by loading the whole word, by setting bits, or by clearing bits. The set and clear addresses touch only the bits written as 1. This lets software change single pins without a read-modify-write and without locking. A pin's alternate-function index is not stored in a field of its own. It is decoded from that pin's function, select and trigger bits. The bank may have fewer than 32 implemented pins.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset every state word reads 0, except the pull-disable word, which reads 1 on every implemented pin. The pad output enables, pull-up enables and function indexes are therefore all 0.
- R2: A write to a state word's offset + 4 sets each bit written as 1 and leaves every other bit of that word unchanged.
- R3: A write to a state word's offset + 8 clears each bit written as 1 and leaves every other bit of that word unchanged.
- R4: A write to a state word's base offset loads the whole word, and a read of the base offset returns it. The base offsets are data 0x10, mask 0x20, pull-disable 0x30, function 0x40, select 0x50, direction 0x60 and trigger 0x70.
- R5: A pin whose direction bit is 1 has its output enable high. Each pin's output value is its data bit.
- R6: The pull-up enable of a pin is the inverse of its pull-disable bit.
- R7: Each pin's 2-bit function index (pins 2i+1..2i of `pad_func`) is decoded as follows:
  - function bit 0: index 0, plain GPIO;
  - function bit 1 and select bit 0: index 1, whatever the trigger bit;
  - function bit 1, select bit 1 and trigger bit 0: index 2;
  - function bit 1, select bit 1 and trigger bit 1: index 3.
- R8: A read of offset 0x00 returns the pin levels through a two-flop synchronizer, whatever the direction bits hold. A pin change made between clock edges is missed by a read sampled at the next two edges and is seen by one sampled at the third.
- R9: Bits above the implemented pin count always read 0, and writes to them have no effect.
- R10: The following accesses have no effect on writes and return 0 on reads:
  - reads of the set and clear offsets;
  - any offset whose bits 3:2 equal 3;
  - any offset of 0x80 or above;
  - any offset that is not word aligned.
  - A write to offset 0x00 also changes nothing.
- R11: `bus_rdata` is loaded at the clock edge where `bus_rd` is high and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset within the bank |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Registered read data |
| pin_in | input | NUM_PINS | Raw pin levels from the pads |
| pad_out | output | NUM_PINS | Output value per pin |
| pad_oe | output | NUM_PINS | Output enable per pin |
| pad_pull_en | output | NUM_PINS | Pull-up enable per pin |
| pad_func | output | 2*NUM_PINS | Alternate-function index, two bits per pin |

## Verification
The assertions take for granted that `bus_wr` and `bus_rd` are each held for one clean cycle per access. They also assume the address decoder never raises more than one of load, set and clear for the same word. They assume `pin_in` changes only between clock edges, so the synchronizer latency is a fixed count of edges. The stimulus drives all bus and pin inputs on the falling edge, issues single-cycle strobes, and never sets and clears the same word in one cycle. That keeps every access inside the one-access-per-cycle model.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

   localparam int unsigned STATE_WORDS = 7;

   // state word index equals offset[7:4] minus one
   typedef enum logic [2:0] {
      SW_DATA = 3'd0,
      SW_MASK = 3'd1,
      SW_PULL = 3'd2,
      SW_FUNC = 3'd3,
      SW_SEL  = 3'd4,
      SW_DIR  = 3'd5,
      SW_TRIG = 3'd6
   } state_word_e;

   // access kind equals offset[3:2]
   typedef enum logic [1:0] {
      ACC_LOAD = 2'd0,
      ACC_SET  = 2'd1,
      ACC_CLR  = 2'd2,
      ACC_NONE = 2'd3
   } access_e;

   typedef struct packed {
      logic        word_hit;
      state_word_e word;
      access_e     kind;
      logic        level_hit;
   } bank_dec_t;

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
   import gpio_bank_pkg::*;
#(
   parameter int unsigned ADDR_W = 8
) (
   input  logic [ADDR_W-1:0] addr,
   output bank_dec_t         dec
);

   logic [ADDR_W-1:0] upper;
   logic [3:0]        slot;
   logic              aligned;

   initial begin
      if (ADDR_W < 8) $fatal(1, "gpio_addr_decode: ADDR_W must be at least 8");
   end

   always_comb begin
      upper   = addr >> 8;
      slot    = addr[7:4];
      aligned = (addr[1:0] == 2'b00) && (upper == '0);

      dec.word      = SW_DATA;
      dec.kind      = ACC_NONE;
      dec.word_hit  = 1'b0;
      dec.level_hit = aligned && (addr[7:0] == 8'h00);

      if (aligned && (slot >= 4'd1) && (slot <= 4'd7) && (addr[3:2] != 2'b11)) begin
         dec.word_hit = 1'b1;
         dec.word     = state_word_e'(3'(slot - 4'd1));
         dec.kind     = access_e'(addr[3:2]);
      end
   end

endmodule

// File: rtl/gpio_state_word.sv
module gpio_state_word #(
   parameter int unsigned         DATA_W   = 32,
   parameter logic [DATA_W-1:0]   RST_VAL  = '0,
   parameter logic [DATA_W-1:0]   LIVE_MSK = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_we,
   input  logic              set_we,
   input  logic              clr_we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q
);

   logic [DATA_W-1:0] wmask;

   assign wmask = wdata & LIVE_MSK;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= RST_VAL & LIVE_MSK;
      end else if (ld_we) begin
         q <= wmask;
      end else if (set_we) begin
         q <= q | wmask;
      end else if (clr_we) begin
         q <= q & ~wmask;
      end
   end

   // R2 R3: the decoder raises at most one access kind per cycle
   p_one_kind_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ld_we, set_we, clr_we}));

   // R2: written ones become set, prior ones stay set
   p_set_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
      set_we |=> (((q & $past(wmask)) == $past(wmask)) && ((q & $past(q)) == $past(q))));

   // R3: written ones become clear, prior zeros stay clear
   p_clr_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we |=> (((q & $past(wmask)) == '0) && ((q | $past(q)) == $past(q))));

   // R10: no access leaves the word untouched
   p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(ld_we || set_we || clr_we) |=> $stable(q));

   // R9: dead bits never hold a one
   p_dead_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (q & ~LIVE_MSK) == '0);

endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   initial begin
      if (STAGES < 2) $fatal(1, "gpio_pin_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= '0;
            else        chain[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];

   // R8: the output is the input delayed by two edges through the first stages
   p_sync_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ##2 (chain[1] == $past(d, 2)));

endmodule

// File: rtl/gpio_func_map.sv
module gpio_func_map #(
   parameter int unsigned NUM_PINS = 32
) (
   input  logic [NUM_PINS-1:0]   fn_en,
   input  logic [NUM_PINS-1:0]   sel,
   input  logic [NUM_PINS-1:0]   trig,
   output logic [2*NUM_PINS-1:0] idx
);

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      logic [1:0] code;
      always_comb begin
         if (!fn_en[p])     code = 2'd0;
         else if (!sel[p])  code = 2'd1;
         else if (!trig[p]) code = 2'd2;
         else               code = 2'd3;
      end
      assign idx[2*p +: 2] = code;

      // R7: plain GPIO exactly when the function bit is low
      always_comb begin
         p_gpio_code_r7: assert ((code == 2'd0) == !fn_en[p]);
      end
   end

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
   import gpio_bank_pkg::*;
#(
   parameter int unsigned NUM_PINS    = 32,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic                  bus_wr,
   input  logic [DATA_W-1:0]     bus_wdata,
   input  logic                  bus_rd,
   output logic [DATA_W-1:0]     bus_rdata,
   input  logic [NUM_PINS-1:0]   pin_in,
   output logic [NUM_PINS-1:0]   pad_out,
   output logic [NUM_PINS-1:0]   pad_oe,
   output logic [NUM_PINS-1:0]   pad_pull_en,
   output logic [2*NUM_PINS-1:0] pad_func
);

   localparam logic [DATA_W-1:0] LIVE_MSK = {DATA_W{1'b1}} >> (DATA_W - NUM_PINS);

   initial begin
      if (NUM_PINS < 1 || NUM_PINS > DATA_W)
         $fatal(1, "gpio_bank_regs: NUM_PINS must be 1..DATA_W");
      if (DATA_W != 32)
         $fatal(1, "gpio_bank_regs: DATA_W must be 32");
   end

   bank_dec_t                             dec;
   logic [STATE_WORDS-1:0][DATA_W-1:0]    st_q;
   logic [NUM_PINS-1:0]                   lvl_sync;
   logic [DATA_W-1:0]                     lvl_word;
   logic [DATA_W-1:0]                     rd_next;

   gpio_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr (bus_addr),
      .dec  (dec)
   );

   for (genvar w = 0; w < STATE_WORDS; w++) begin : g_word
      localparam logic [DATA_W-1:0] RST = (w == int'(SW_PULL)) ? LIVE_MSK : '0;
      logic sel_w;
      assign sel_w = bus_wr && dec.word_hit && (int'(dec.word) == w);
      gpio_state_word #(
         .DATA_W   (DATA_W),
         .RST_VAL  (RST),
         .LIVE_MSK (LIVE_MSK)
      ) u_word (
         .clk    (clk),
         .rst_n  (rst_n),
         .ld_we  (sel_w && (dec.kind == ACC_LOAD)),
         .set_we (sel_w && (dec.kind == ACC_SET)),
         .clr_we (sel_w && (dec.kind == ACC_CLR)),
         .wdata  (bus_wdata),
         .q      (st_q[w])
      );
   end

   gpio_pin_sync #(
      .WIDTH  (NUM_PINS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (lvl_sync)
   );

   assign lvl_word = DATA_W'(lvl_sync);

   gpio_func_map #(.NUM_PINS(NUM_PINS)) u_fmap (
      .fn_en (st_q[int'(SW_FUNC)][NUM_PINS-1:0]),
      .sel   (st_q[int'(SW_SEL)][NUM_PINS-1:0]),
      .trig  (st_q[int'(SW_TRIG)][NUM_PINS-1:0]),
      .idx   (pad_func)
   );

   assign pad_out     = st_q[int'(SW_DATA)][NUM_PINS-1:0];
   assign pad_oe      = st_q[int'(SW_DIR)][NUM_PINS-1:0];
   assign pad_pull_en = ~st_q[int'(SW_PULL)][NUM_PINS-1:0];

   always_comb begin
      if (dec.level_hit)
         rd_next = lvl_word;
      else if (dec.word_hit && dec.kind == ACC_LOAD)
         rd_next = st_q[dec.word];
      else
         rd_next = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_next;
   end

   // R10: alias and unmapped reads return zero
   p_alias_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !dec.level_hit && !(dec.word_hit && dec.kind == ACC_LOAD)) |=> (bus_rdata == '0));

   // R11: read data holds between reads
   p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata));

   // R9: no read ever shows a bit above the pin count
   p_rd_dead_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rdata & ~LIVE_MSK) == '0);

   // R6: pull-up enable and pull-disable are never both set for a pin
   p_pull_inv_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_pull_en & st_q[int'(SW_PULL)][NUM_PINS-1:0]) == '0);

endmodule

// File: tb/tb_gpio_bank_regs.sv
module tb_gpio_bank_regs;

   localparam int NP = 31;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [7:0]    bus_addr = '0;
   logic          bus_wr = 1'b0;
   logic [31:0]   bus_wdata = '0;
   logic          bus_rd = 1'b0;
   logic [31:0]   bus_rdata;
   logic [NP-1:0] pin_in = '0;
   logic [NP-1:0] pad_out, pad_oe, pad_pull_en;
   logic [2*NP-1:0] pad_func;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   gpio_bank_regs #(.NUM_PINS(NP)) dut (
      .clk, .rst_n, .bus_addr, .bus_wr, .bus_wdata, .bus_rd, .bus_rdata,
      .pin_in, .pad_out, .pad_oe, .pad_pull_en, .pad_func
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk); @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a; bus_rd = 1'b1;
      @(posedge clk); @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(8'h10, v); check("R1 data", v, 0);
      rd(8'h30, v); check("R1 pull", v, 32'h7FFF_FFFF);
      rd(8'h60, v); check("R1 dir", v, 0);
      check("R1 oe", pad_oe, 0);
      check("R1 pull_en", pad_pull_en, 0);
      check("R1 func", pad_func, 0);
   endtask

   task automatic t_set_clear();
      logic [31:0] v;
      wr(8'h14, 32'h0000_00F0);
      rd(8'h10, v); check("R2 set", v, 32'h0000_00F0);
      wr(8'h14, 32'h0F00_0001);
      rd(8'h10, v); check("R2 set keep", v, 32'h0F00_00F1);
      wr(8'h18, 32'h0000_0030);
      rd(8'h10, v); check("R3 clear", v, 32'h0F00_00C1);
      wr(8'h24, 32'h0000_00A5);
      wr(8'h28, 32'h0000_0005);
      rd(8'h20, v); check("R3 mask clear", v, 32'h0000_00A0);
   endtask

   task automatic t_load();
      logic [31:0] v;
      wr(8'h60, 32'h1234_5678);
      rd(8'h60, v); check("R4 load", v, 32'h1234_5678);
      wr(8'h60, 32'h0);
      rd(8'h60, v); check("R4 reload", v, 0);
   endtask

   task automatic t_direction();
      wr(8'h10, 32'h0000_0005);
      wr(8'h64, 32'h0000_0003);
      check("R5 oe", pad_oe, 31'h3);
      check("R5 out", pad_out, 31'h5);
   endtask

   task automatic t_pull();
      wr(8'h38, 32'h0000_000F);
      check("R6 pull on", pad_pull_en, 31'hF);
      wr(8'h34, 32'h0000_0003);
      check("R6 pull off", pad_pull_en, 31'hC);
   endtask

   task automatic t_func();
      wr(8'h44, 32'h0000_001E);
      wr(8'h54, 32'h0000_002C);
      wr(8'h74, 32'h0000_0038);
      check("R7 func idx", pad_func[11:0], 12'h1E4);
   endtask

   task automatic t_sync();
      logic [31:0] v;
      pin_in = 31'h1234_5678;
      rd(8'h00, v); check("R8 early", v, 0);
      @(negedge clk);
      rd(8'h00, v); check("R8 level", v, 32'h1234_5678);
   endtask

   task automatic t_unimpl();
      logic [31:0] v;
      wr(8'h10, 32'hFFFF_FFFF);
      rd(8'h10, v); check("R9 dead bit", v, 32'h7FFF_FFFF);
      wr(8'h10, 32'h0000_0042);
   endtask

   task automatic t_unmapped();
      logic [31:0] v;
      rd(8'h14, v); check("R10 alias rd", v, 0);
      rd(8'h90, v); check("R10 high rd", v, 0);
      rd(8'h12, v); check("R10 misalign rd", v, 0);
      wr(8'h00, 32'hFFFF_FFFF);
      wr(8'h1C, 32'hFFFF_FFFF);
      wr(8'h8C, 32'hFFFF_FFFF);
      wr(8'h11, 32'hFFFF_FFFF);
      rd(8'h10, v); check("R10 no write", v, 32'h0000_0042);
   endtask

   task automatic t_read_hold();
      logic [31:0] v;
      rd(8'h10, v);
      wr(8'h18, 32'h0000_0002);
      @(negedge clk); @(negedge clk);
      check("R11 hold", bus_rdata, 32'h0000_0042);
      rd(8'h10, v); check("R11 new read", v, 32'h0000_0040);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_set_clear();
      t_load();
      t_direction();
      t_pull();
      t_func();
      t_sync();
      t_unimpl();
      t_unmapped();
      t_read_hold();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule